// File: doc/BRIEF.md
# Blit Row Sequencer

This block drives a rectangle copy between two 4-bit-per-pixel bitmaps, one row at a time. A start pulse latches both bitmap descriptions (base word address, words per raster line, height in lines, width in bits, bits per pixel), the source and destination corner coordinates, the transfer width and height, and a resume width. The block then checks the request. If the request is legal, it hands one line command per row to a separate line engine and waits for that engine to finish or abort the row.

Rows are walked from the bottom of the rectangle upward. Because of this, the only state needed to pick up an operation that stopped between rows is the remaining height. A row aborted part way through is reported with its remaining pixel count. Restarting with that count as the resume width makes the first row begin at an X offset of transfer width minus resume width. Every later row starts at offset zero and covers the full transfer width. An interrupt request is looked at only when a row completes.

Top module: `blit_row_seq`

## Requirements
- R1: Both bits-per-pixel inputs must equal 4. Any other value on either one ends the operation with `op_err` set and no line command issued.
- R2: The pixel width of a bitmap is its width in bits shifted right by 2. The request is rejected (`op_err`, no command) unless, for both source and destination, Y < height, Y + transfer height <= height, X < pixel width, and X + transfer width <= pixel width.
- R3: When the transfer height is zero and R1 and R4 pass, the operation ends with `op_done` set, no error and no line command. The bounds of R2 are not checked in this case.
- R4: A resume width larger than the transfer width, or a transfer width of zero, is rejected with `op_err` and no command.
- R5: Exactly one command is issued per remaining row, for remaining-height values k = H, H-1, …, 1. After each completed row the remaining height `rem_h_o` drops by one, and the operation ends with `op_done` when it reaches zero.
- R6: For remaining height k and X offset o, the source word address is base + (bitmap height − (Y + k)) × raster width + ((X + o) >> 2). The destination address uses the same formula with the destination fields. The sum is taken over the full address width, so a carry out of the low 16 bits reaches the upper bits.
- R7: `cmd_src_phase` and `cmd_dst_phase` are (X + o) mod 4 for source and destination respectively. `cmd_parity` is bit 0 of destination Y + k − 1.
- R8: With a nonzero resume width r, the first row uses o = transfer width − r and count r. With r = 0, and on every later row, o = 0 and the count is the transfer width.
- R9: If `irq_pending` is high in the cycle a row completes and rows remain, the block stops with `op_susp` set, `rem_h_o` equal to the rows not yet done, `rem_w_o` = 0, and no further command.
- R10: A `line_abort` stops the block with `op_fault` set. `rem_h_o` is left unchanged (the aborted row still counts) and `rem_w_o` takes the value of `line_left`.
- R11: A command whose `cmd_ready` is low stays valid with all fields unchanged.
- R12: After an operation, `busy` is low and exactly one of `op_done`, `op_err`, `op_susp`, `op_fault` is set. All four are cleared by the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Latch parameters and begin |
| src_base | input | AW | Source word address of top-left row |
| src_raster | input | CW | Source words per raster line |
| src_height | input | CW | Source height in lines |
| src_wbits | input | CW | Source width in bits |
| src_bpp | input | BW | Source bits per pixel |
| dst_base | input | AW | Destination word address of top-left row |
| dst_raster | input | CW | Destination words per raster line |
| dst_height | input | CW | Destination height in lines |
| dst_wbits | input | CW | Destination width in bits |
| dst_bpp | input | BW | Destination bits per pixel |
| src_x | input | CW | Source rectangle X |
| src_y | input | CW | Source rectangle Y |
| dst_x | input | CW | Destination rectangle X |
| dst_y | input | CW | Destination rectangle Y |
| xfer_w | input | CW | Transfer width in pixels |
| xfer_h | input | CW | Transfer height in lines |
| resume_w | input | CW | Pixels left from an aborted row, 0 for a fresh start |
| irq_pending | input | 1 | Interrupt request, sampled at row completion |
| cmd_valid | output | 1 | Line command valid |
| cmd_ready | input | 1 | Line engine accepts command |
| cmd_src_addr | output | AW | Source word address of row |
| cmd_dst_addr | output | AW | Destination word address of row |
| cmd_src_phase | output | 2 | Source starting nibble |
| cmd_dst_phase | output | 2 | Destination starting nibble |
| cmd_parity | output | 1 | Destination row Y parity |
| cmd_count | output | CW | Pixels in the row |
| line_done | input | 1 | Row finished |
| line_abort | input | 1 | Row aborted |
| line_left | input | CW | Pixels not done at abort |
| busy | output | 1 | Operation in progress |
| op_done | output | 1 | Completed |
| op_err | output | 1 | Rejected |
| op_susp | output | 1 | Suspended between rows |
| op_fault | output | 1 | Stopped by row abort |
| rem_h_o | output | CW | Remaining height |
| rem_w_o | output | CW | Untransferred width |

## Verification
The hardest case to reach from the ports is the resume path. A resumed operation must produce row addresses and offsets that join seamlessly with the rows done before the stop. To reach it, the bench sweeps every resume width from zero to the transfer width over many rectangle placements. It also runs an abort followed by a restart built from `rem_h_o` and `rem_w_o`, and an interrupt followed by a restart with the reported height. The expected addresses for each row come from the same arithmetic in every case. Base addresses sit just below a 64K-word boundary, so the carry into the upper address bits is exercised on most rows.

// File: rtl/blit_row_seq.sv
module blit_row_seq #(
  parameter int AW      = 24,
  parameter int CW      = 16,
  parameter int BW      = 4,
  parameter int NIB_BPP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_base,
  input  logic [CW-1:0] src_raster,
  input  logic [CW-1:0] src_height,
  input  logic [CW-1:0] src_wbits,
  input  logic [BW-1:0] src_bpp,
  input  logic [AW-1:0] dst_base,
  input  logic [CW-1:0] dst_raster,
  input  logic [CW-1:0] dst_height,
  input  logic [CW-1:0] dst_wbits,
  input  logic [BW-1:0] dst_bpp,
  input  logic [CW-1:0] src_x,
  input  logic [CW-1:0] src_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic [CW-1:0] xfer_w,
  input  logic [CW-1:0] xfer_h,
  input  logic [CW-1:0] resume_w,
  input  logic          irq_pending,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [AW-1:0] cmd_src_addr,
  output logic [AW-1:0] cmd_dst_addr,
  output logic [1:0]    cmd_src_phase,
  output logic [1:0]    cmd_dst_phase,
  output logic          cmd_parity,
  output logic [CW-1:0] cmd_count,
  input  logic          line_done,
  input  logic          line_abort,
  input  logic [CW-1:0] line_left,
  output logic          busy,
  output logic          op_done,
  output logic          op_err,
  output logic          op_susp,
  output logic          op_fault,
  output logic [CW-1:0] rem_h_o,
  output logic [CW-1:0] rem_w_o
);

  localparam int CX = CW + 1;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_ISSUE, S_WAIT} st_t;
  st_t st;

  logic [AW-1:0] sb_q, db_q;
  logic [CW-1:0] sr_q, sh_q, swb_q, dr_q, dh_q, dwb_q;
  logic [BW-1:0] sbpp_q, dbpp_q;
  logic [CW-1:0] sx_q, sy_q, dx_q, dy_q, w_q, r_q;
  logic [CW-1:0] rem_h, rem_w, off_q;

  function automatic logic rect_ok(input logic [CW-1:0] x, input logic [CW-1:0] y,
                                   input logic [CW-1:0] pw, input logic [CW-1:0] ht,
                                   input logic [CW-1:0] w, input logic [CW-1:0] h);
    logic [CX-1:0] xe, ye;
    xe = {1'b0, x} + {1'b0, w};
    ye = {1'b0, y} + {1'b0, h};
    return (x < pw) && (y < ht) && (xe <= {1'b0, pw}) && (ye <= {1'b0, ht});
  endfunction

  logic [CW-1:0] spw, dpw;
  logic          bpp_bad, size_bad, rect_bad, req_bad;

  assign spw      = swb_q >> 2;
  assign dpw      = dwb_q >> 2;
  assign bpp_bad  = (sbpp_q != BW'(NIB_BPP)) || (dbpp_q != BW'(NIB_BPP));
  assign size_bad = (r_q > w_q) || (w_q == '0);
  assign rect_bad = (rem_h != '0) &&
                    !(rect_ok(sx_q, sy_q, spw, sh_q, w_q, rem_h) &&
                      rect_ok(dx_q, dy_q, dpw, dh_q, w_q, rem_h));
  assign req_bad  = bpp_bad || size_bad || rect_bad;

  logic [CW-1:0] sxo, dxo, srow, drow, dyrow;

  assign sxo   = sx_q + off_q;
  assign dxo   = dx_q + off_q;
  assign srow  = sh_q - (sy_q + rem_h);
  assign drow  = dh_q - (dy_q + rem_h);
  assign dyrow = dy_q + rem_h - CW'(1);

  assign cmd_valid     = (st == S_ISSUE);
  assign cmd_src_addr  = sb_q + AW'(srow) * AW'(sr_q) + AW'(sxo >> 2);
  assign cmd_dst_addr  = db_q + AW'(drow) * AW'(dr_q) + AW'(dxo >> 2);
  assign cmd_src_phase = sxo[1:0];
  assign cmd_dst_phase = dxo[1:0];
  assign cmd_parity    = dyrow[0];
  assign cmd_count     = w_q - off_q;

  assign busy    = (st != S_IDLE);
  assign rem_h_o = rem_h;
  assign rem_w_o = rem_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sb_q     <= '0;
      db_q     <= '0;
      sr_q     <= '0;
      sh_q     <= '0;
      swb_q    <= '0;
      dr_q     <= '0;
      dh_q     <= '0;
      dwb_q    <= '0;
      sbpp_q   <= '0;
      dbpp_q   <= '0;
      sx_q     <= '0;
      sy_q     <= '0;
      dx_q     <= '0;
      dy_q     <= '0;
      w_q      <= '0;
      r_q      <= '0;
      rem_h    <= '0;
      rem_w    <= '0;
      off_q    <= '0;
      op_done  <= 1'b0;
      op_err   <= 1'b0;
      op_susp  <= 1'b0;
      op_fault <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          sb_q     <= src_base;
          db_q     <= dst_base;
          sr_q     <= src_raster;
          sh_q     <= src_height;
          swb_q    <= src_wbits;
          dr_q     <= dst_raster;
          dh_q     <= dst_height;
          dwb_q    <= dst_wbits;
          sbpp_q   <= src_bpp;
          dbpp_q   <= dst_bpp;
          sx_q     <= src_x;
          sy_q     <= src_y;
          dx_q     <= dst_x;
          dy_q     <= dst_y;
          w_q      <= xfer_w;
          r_q      <= resume_w;
          rem_h    <= xfer_h;
          rem_w    <= '0;
          op_done  <= 1'b0;
          op_err   <= 1'b0;
          op_susp  <= 1'b0;
          op_fault <= 1'b0;
          st       <= S_CHECK;
        end
        S_CHECK: begin
          if (req_bad) begin
            op_err <= 1'b1;
            st     <= S_IDLE;
          end else if (rem_h == '0) begin
            op_done <= 1'b1;
            st      <= S_IDLE;
          end else begin
            off_q <= (r_q != '0) ? (w_q - r_q) : '0;
            st    <= S_ISSUE;
          end
        end
        S_ISSUE: if (cmd_ready) st <= S_WAIT;
        S_WAIT: begin
          if (line_abort) begin
            rem_w    <= line_left;
            op_fault <= 1'b1;
            st       <= S_IDLE;
          end else if (line_done) begin
            rem_h <= rem_h - CW'(1);
            off_q <= '0;
            if (rem_h == CW'(1)) begin
              op_done <= 1'b1;
              st      <= S_IDLE;
            end else if (irq_pending) begin
              op_susp <= 1'b1;
              st      <= S_IDLE;
            end else begin
              st <= S_ISSUE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_src_addr) && $stable(cmd_dst_addr) && $stable(cmd_count)); // R11
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> !cmd_valid); // R1
  AST_ONE_END: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_done, op_err, op_susp, op_fault})); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid); // R12
  AST_SUSP_W0: assert property (@(posedge clk) disable iff (!rst_n)
    op_susp |-> rem_w_o == '0); // R9
  AST_ROW_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) && line_done && !line_abort |=> rem_h_o == $past(rem_h_o) - CW'(1)); // R5
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_count != '0) && (cmd_count <= w_q)); // R8

endmodule

// File: tb/tb_blit_row_seq.sv
module tb_blit_row_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int CW = 16;
  localparam int BW = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] src_base = '0, dst_base = '0;
  logic [CW-1:0] src_raster = '0, src_height = '0, src_wbits = '0;
  logic [CW-1:0] dst_raster = '0, dst_height = '0, dst_wbits = '0;
  logic [BW-1:0] src_bpp = '0, dst_bpp = '0;
  logic [CW-1:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0;
  logic [CW-1:0] xfer_w = '0, xfer_h = '0, resume_w = '0, line_left = '0;
  logic irq_pending = 1'b0, cmd_ready = 1'b0, line_done = 1'b0, line_abort = 1'b0;
  logic cmd_valid, cmd_parity, busy, op_done, op_err, op_susp, op_fault;
  logic [AW-1:0] cmd_src_addr, cmd_dst_addr;
  logic [1:0] cmd_src_phase, cmd_dst_phase;
  logic [CW-1:0] cmd_count, rem_h_o, rem_w_o;

  blit_row_seq #(.AW(AW), .CW(CW), .BW(BW), .NIB_BPP(4)) dut (
    .clk, .rst_n, .start, .src_base, .src_raster, .src_height, .src_wbits, .src_bpp,
    .dst_base, .dst_raster, .dst_height, .dst_wbits, .dst_bpp,
    .src_x, .src_y, .dst_x, .dst_y, .xfer_w, .xfer_h, .resume_w, .irq_pending,
    .cmd_valid, .cmd_ready, .cmd_src_addr, .cmd_dst_addr, .cmd_src_phase, .cmd_dst_phase,
    .cmd_parity, .cmd_count, .line_done, .line_abort, .line_left,
    .busy, .op_done, .op_err, .op_susp, .op_fault, .rem_h_o, .rem_w_o);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int sbase, sr, sh, swb, sbpp, dbase, dr, dh, dwb, dbpp;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit rect(int x, int y, int pw, int ht, int w, int h);
    return (x < pw) && (y < ht) && (x + w <= pw) && (y + h <= ht);
  endfunction

  task automatic run_op(input int sx, input int sy, input int dx, input int dy,
                        input int w, input int h, input int res,
                        input int abort_k, input int abort_left, input int irq_k);
    int k, kind, nlines, guard, off;
    bit bad, ended;
    longint ea, eb, hold_s;
    @(negedge clk);
    src_base = AW'(sbase); src_raster = CW'(sr); src_height = CW'(sh); src_wbits = CW'(swb); src_bpp = BW'(sbpp);
    dst_base = AW'(dbase); dst_raster = CW'(dr); dst_height = CW'(dh); dst_wbits = CW'(dwb); dst_bpp = BW'(dbpp);
    src_x = CW'(sx); src_y = CW'(sy); dst_x = CW'(dx); dst_y = CW'(dy);
    xfer_w = CW'(w); xfer_h = CW'(h); resume_w = CW'(res);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bad = (sbpp != 4) || (dbpp != 4) || (res > w) || (w == 0) ||
          (h != 0 && !(rect(sx, sy, swb >> 2, sh, w, h) && rect(dx, dy, dwb >> 2, dh, w, h)));
    kind = bad ? 1 : 0;
    k = h; nlines = 0; guard = 0; ended = 0;
    off = (res != 0) ? w - res : 0;
    while (!ended) begin
      guard++;
      if (guard > 400) begin
        chk(0, "R5 operation hung", guard, 0);
        ended = 1;
      end else if (!busy) begin
        ended = 1;
      end else if (cmd_valid) begin
        nlines++;
        chk(!bad && k > 0, "R1/R2/R4 command on rejected or finished op", k, 0);
        ea = (longint'(sbase) + longint'(sh - (sy + k)) * sr + ((sx + off) >> 2)) & 64'hFFFFFF;
        eb = (longint'(dbase) + longint'(dh - (dy + k)) * dr + ((dx + off) >> 2)) & 64'hFFFFFF;
        chk(cmd_src_addr == AW'(ea), "R6 source address", cmd_src_addr, ea);
        chk(cmd_dst_addr == AW'(eb), "R6 destination address", cmd_dst_addr, eb);
        chk(cmd_src_phase == 2'((sx + off) & 3) && cmd_dst_phase == 2'((dx + off) & 3),
            "R7 phases", {cmd_src_phase, cmd_dst_phase}, {2'((sx + off) & 3), 2'((dx + off) & 3)});
        chk(cmd_parity == 1'((dy + k - 1) & 1), "R7 parity", cmd_parity, (dy + k - 1) & 1);
        chk(cmd_count == CW'(w - off), "R8 row count", cmd_count, w - off);
        hold_s = cmd_src_addr;
        @(negedge clk);
        chk(cmd_valid && cmd_src_addr == AW'(hold_s), "R11 command held", cmd_src_addr, hold_s);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        @(negedge clk);
        if (k == abort_k) begin
          line_abort = 1'b1;
          line_left = CW'(abort_left);
        end else begin
          line_done = 1'b1;
        end
        irq_pending = (k == irq_k);
        @(negedge clk);
        line_abort = 1'b0; line_done = 1'b0; irq_pending = 1'b0;
        if (k == abort_k) kind = 3;
        else begin
          k--; off = 0;
          if (k > 0 && k + 1 == irq_k) kind = 2;
        end
      end else begin
        @(negedge clk);
      end
    end
    chk(!busy && !cmd_valid, "R12 idle after op", busy, 0);
    case (kind)
      1: begin
        chk(op_err && !op_done && !op_susp && !op_fault, "R1/R2/R4 reject flags",
            {op_done, op_err, op_susp, op_fault}, 4'b0100);
        chk(nlines == 0, "R1/R2/R4 no command", nlines, 0);
      end
      0: begin
        chk(op_done && !op_err && !op_susp && !op_fault, "R5/R3 done flags",
            {op_done, op_err, op_susp, op_fault}, 4'b1000);
        chk(nlines == h, "R5 rows issued", nlines, h);
        chk(rem_h_o == 0, "R5 remaining height", rem_h_o, 0);
      end
      2: begin
        chk(op_susp && !op_done && !op_err && !op_fault, "R9 suspend flags",
            {op_done, op_err, op_susp, op_fault}, 4'b0010);
        chk(rem_h_o == CW'(k) && rem_w_o == 0, "R9 suspend state", {rem_h_o, rem_w_o}, {CW'(k), CW'(0)});
      end
      default: begin
        chk(op_fault && !op_done && !op_err && !op_susp, "R10 fault flags",
            {op_done, op_err, op_susp, op_fault}, 4'b0001);
        chk(rem_h_o == CW'(k) && rem_w_o == CW'(abort_left), "R10 fault state",
            {rem_h_o, rem_w_o}, {CW'(k), CW'(abort_left)});
      end
    endcase
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    sbase = 24'h00FFFE; sr = 3; sh = 7; swb = 40; sbpp = 4;
    dbase = 24'h12FFFF; dr = 3; dh = 6; dwb = 36; dbpp = 4;
    repeat (3) @(negedge clk);
    chk(!busy && !cmd_valid && !op_done && !op_err && !op_susp && !op_fault, "R12 reset state",
        {busy, cmd_valid, op_done, op_err, op_susp, op_fault}, 0);
    rst_n = 1'b1;

    for (int sx = 0; sx <= 10; sx++)
      for (int w = 1; w <= 10; w++)
        run_op(sx, 0, 0, 0, w, 1, 0, -1, 0, -1);           // R2 X bounds
    for (int sy = 0; sy <= 7; sy++)
      for (int h = 1; h <= 8; h++)
        run_op(0, sy, 0, 0, 1, h, 0, -1, 0, -1);           // R2 Y bounds

    for (int dx = 0; dx <= 5; dx++)
      for (int w = 1; w <= 4; w++)
        for (int h = 1; h <= 3; h++)
          for (int dy = 0; dy <= 2; dy++)
            for (int res = 0; res <= w; res++)
              run_op(dx + 1, dy + 2, dx, dy, w, h, res, -1, 0, -1); // R5 R6 R7 R8

    sbpp = 8; run_op(0, 0, 0, 0, 2, 2, 0, -1, 0, -1); sbpp = 4;  // R1
    dbpp = 1; run_op(0, 0, 0, 0, 2, 2, 0, -1, 0, -1); dbpp = 4;  // R1
    run_op(0, 0, 0, 0, 2, 0, 0, -1, 0, -1);                     // R3
    run_op(20, 20, 20, 20, 2, 0, 0, -1, 0, -1);                 // R3 bounds skipped
    run_op(0, 0, 0, 0, 2, 0, 3, -1, 0, -1);                     // R4 with zero height
    run_op(0, 0, 0, 0, 2, 1, 3, -1, 0, -1);                     // R4
    run_op(0, 0, 0, 0, 0, 1, 0, -1, 0, -1);                     // R4 zero width

    run_op(1, 1, 2, 1, 4, 3, 0, -1, 0, 3);                      // R9 stop after first row
    run_op(1, 1, 2, 1, 4, 2, 0, -1, 0, -1);                     // R9 continue
    run_op(1, 1, 2, 1, 4, 3, 0, -1, 0, 1);                      // R9 irq on last row: done
    run_op(1, 1, 2, 1, 4, 3, 0, 3, 3, -1);                      // R10 abort first row
    run_op(1, 1, 2, 1, 4, 3, 3, -1, 0, -1);                     // R10 R8 restart
    run_op(1, 1, 2, 1, 4, 3, 0, 2, 1, -1);                      // R10 abort middle row
    run_op(1, 1, 2, 1, 4, 2, 1, -1, 0, -1);                     // R8 restart offset 3

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule